// File: doc/BRIEF.md
# Transceiver Power-Mode Controller

This block keeps the power state of a fast-Ethernet transceiver and drives the enable lines of its subsystems. There are four saving modes. Three are set by software through management control bits: power-down, analog shutdown and link-down saving. Link-down saving can also be requested by a strap pin. Isolation comes only from a second strap pin. When more than one mode is requested, the one with the highest priority decides every output.

In link-down saving the transmitter stays powered. While the link is down it sends reduced wake-up pulses in place of its normal link signalling. When the receiver reports incoming energy, the transmitter returns to normal signalling. It falls back to the reduced pulses only if the link comes up and later drops again.

The software bits, link status and energy strobe each pass through one register. Both strap pins pass through a two-stage synchronizer. Every output is decoded from registered state.

Top module: `phy_pwr_mode_ctrl`

## Requirements
- R1: Mode priority, from highest to lowest, is isolation, power-down, analog shutdown, link-down saving, normal. All outputs follow the highest-priority active mode.
- R2: In normal mode afe_en, pll_en, tx_en, dp_en, mgmt_en and mac_oe are 1 and wake_pulse_sel is 0.
- R3: In analog shutdown afe_en, pll_en and tx_en are 0. dp_en, mgmt_en and mac_oe are 1. wake_pulse_sel is 0.
- R4: In power-down only mgmt_en is 1. All other outputs are 0.
- R5: In isolation every output is 0, including mgmt_en and mac_oe.
- R6: Link-down saving is requested by cfg_ldps or by pin_ldps_strap. All enables stay 1 in this mode. wake_pulse_sel is 1 (reduced pulses) while the registered link status is down, and 0 while it is up.
- R7: In link-down saving with the link down, a 1 on rx_energy_det makes wake_pulse_sel go to 0 at the second rising edge after the strobe is sampled. It stays 0 while the link remains down.
- R8: In link-down saving, if the link goes up and then drops, wake_pulse_sel returns to 1 at the first edge that registers the drop.
- R9: An rx_energy_det strobe has no lasting effect outside link-down saving, or while the link is up.
- R10: Software bits and link_up act one rising edge after they are sampled. Strap pins act two rising edges after they are sampled. Clearing a software bit restores the enables at the next edge.
- R11: During reset and right after it, the outputs show normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_pdn | input | 1 | Software power-down bit |
| cfg_aoff | input | 1 | Software analog-shutdown bit |
| cfg_ldps | input | 1 | Software link-down-saving bit |
| pin_ldps_strap | input | 1 | Link-down-saving strap pin, asynchronous |
| pin_iso_strap | input | 1 | Isolation strap pin, asynchronous |
| link_up | input | 1 | Link status, 1 = up |
| rx_energy_det | input | 1 | Receive-energy strobe |
| afe_en | output | 1 | Analog front-end enable |
| pll_en | output | 1 | PLL enable |
| tx_en | output | 1 | Transmitter enable |
| dp_en | output | 1 | Digital datapath enable |
| mgmt_en | output | 1 | Management interface enable |
| mac_oe | output | 1 | MAC-side output enable |
| wake_pulse_sel | output | 1 | 1 = reduced wake-up pulses, 0 = normal link pulses |

## Verification
Two events can land in the same cycle: a drop of the registered link and an energy strobe. The first should turn the reduced pulses on, and the second should turn them off. The bench raises the link, then lowers link_up and raises rx_energy_det in the same sampled cycle. The expected result is wake_pulse_sel at 1 for exactly one cycle, then 0. The bench also sets power-down and link-down saving together, with the link down, and expects the power-down outputs with wake_pulse_sel at 0.

// File: rtl/phy_pwr_pkg.sv
package phy_pwr_pkg;

  typedef enum logic [2:0] {
    MODE_NORMAL = 3'd0,
    MODE_LDPS   = 3'd1,
    MODE_AOFF   = 3'd2,
    MODE_PDN    = 3'd3,
    MODE_ISO    = 3'd4
  } pwr_mode_e;

  typedef struct packed {
    logic afe;
    logic pll;
    logic tx;
    logic dp;
    logic mgmt;
    logic mac_oe;
  } pwr_en_s;

  // Highest-priority active request wins.
  function automatic pwr_mode_e pick_mode(input logic iso, input logic pdn,
                                          input logic aoff, input logic ldps);
    if (iso)       return MODE_ISO;
    else if (pdn)  return MODE_PDN;
    else if (aoff) return MODE_AOFF;
    else if (ldps) return MODE_LDPS;
    else           return MODE_NORMAL;
  endfunction

  // Subsystems kept alive in each mode.
  function automatic pwr_en_s mode_enables(input pwr_mode_e m);
    pwr_en_s e;
    case (m)
      MODE_ISO:  e = '{afe:1'b0, pll:1'b0, tx:1'b0, dp:1'b0, mgmt:1'b0, mac_oe:1'b0};
      MODE_PDN:  e = '{afe:1'b0, pll:1'b0, tx:1'b0, dp:1'b0, mgmt:1'b1, mac_oe:1'b0};
      MODE_AOFF: e = '{afe:1'b0, pll:1'b0, tx:1'b0, dp:1'b1, mgmt:1'b1, mac_oe:1'b1};
      default:   e = '{afe:1'b1, pll:1'b1, tx:1'b1, dp:1'b1, mgmt:1'b1, mac_oe:1'b1};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[LAST];
endmodule

// File: rtl/pwr_mode_arb.sv
module pwr_mode_arb
  import phy_pwr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_pdn,
  input  logic      cfg_aoff,
  input  logic      cfg_ldps,
  input  logic      iso_s,
  input  logic      ldps_pin_s,
  output pwr_mode_e mode
);
  logic pdn_q, aoff_q, ldps_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdn_q  <= 1'b0;
      aoff_q <= 1'b0;
      ldps_q <= 1'b0;
    end else begin
      pdn_q  <= cfg_pdn;
      aoff_q <= cfg_aoff;
      ldps_q <= cfg_ldps;
    end
  end

  assign mode = pick_mode(iso_s, pdn_q, aoff_q, ldps_q | ldps_pin_s);

  // R10: clearing the bit releases power-down at the very next edge
  p_pdn_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_pdn) == 1'b0 |-> mode != MODE_PDN);

  // R1: isolation overrides every software request
  p_iso_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    iso_s |-> mode == MODE_ISO);
endmodule

// File: rtl/pwr_ldps_seq.sv
module pwr_ldps_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic ldps_active,
  input  logic link_up,
  input  logic rx_energy_det,
  output logic reduced
);
  logic link_q, energy_q, woke;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q   <= 1'b0;
      energy_q <= 1'b0;
    end else begin
      link_q   <= link_up;
      energy_q <= rx_energy_det;
    end
  end

  // Wake flag: set by energy while waiting for a link, cleared by link-up or mode exit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     woke <= 1'b0;
    else if (!ldps_active || link_q) woke <= 1'b0;
    else if (energy_q)              woke <= 1'b1;
  end

  assign reduced = ldps_active & ~link_q & ~woke;

  // R7: energy seen while waiting stops the reduced pulses next cycle
  p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ldps_active && !link_q && energy_q |=> !reduced);

  // R8: a drop of an established link re-arms the reduced pulses
  p_relapse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ldps_active && $fell(link_q) |-> reduced);
endmodule

// File: rtl/phy_pwr_mode_ctrl.sv
module phy_pwr_mode_ctrl
  import phy_pwr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_pdn,
  input  logic cfg_aoff,
  input  logic cfg_ldps,
  input  logic pin_ldps_strap,
  input  logic pin_iso_strap,
  input  logic link_up,
  input  logic rx_energy_det,
  output logic afe_en,
  output logic pll_en,
  output logic tx_en,
  output logic dp_en,
  output logic mgmt_en,
  output logic mac_oe,
  output logic wake_pulse_sel
);
  localparam int NPINS = 2;

  logic [NPINS-1:0] pins_s;
  logic             iso_s, ldps_pin_s;
  pwr_mode_e        mode;
  pwr_en_s          en;
  logic             ldps_active, reduced;

  pwr_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({pin_iso_strap, pin_ldps_strap}), .q(pins_s)
  );
  assign iso_s      = pins_s[1];
  assign ldps_pin_s = pins_s[0];

  pwr_mode_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .cfg_pdn(cfg_pdn), .cfg_aoff(cfg_aoff), .cfg_ldps(cfg_ldps),
    .iso_s(iso_s), .ldps_pin_s(ldps_pin_s), .mode(mode)
  );

  assign ldps_active = (mode == MODE_LDPS);

  pwr_ldps_seq u_seq (
    .clk(clk), .rst_n(rst_n), .ldps_active(ldps_active),
    .link_up(link_up), .rx_energy_det(rx_energy_det), .reduced(reduced)
  );

  assign en             = mode_enables(mode);
  assign afe_en         = en.afe;
  assign pll_en         = en.pll;
  assign tx_en          = en.tx;
  assign dp_en          = en.dp;
  assign mgmt_en        = en.mgmt;
  assign mac_oe         = en.mac_oe;
  assign wake_pulse_sel = reduced;

  // R5: synchronized isolation shuts every output
  p_iso_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iso_s |-> !(afe_en | pll_en | tx_en | dp_en | mgmt_en | mac_oe | wake_pulse_sel));

  // R4: management stays reachable whenever the chip is not isolated
  p_mgmt_alive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !iso_s |-> mgmt_en);

  // R6: reduced pulses only with the transmitter and analog side powered
  p_pulse_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse_sel |-> tx_en && afe_en && pll_en);

  // R3: datapath never runs without management access
  p_dp_mgmt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dp_en |-> mgmt_en && mac_oe);
endmodule

// File: tb/tb_phy_pwr_mode_ctrl.sv
module tb_phy_pwr_mode_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_pdn = 0, cfg_aoff = 0, cfg_ldps = 0;
  logic pin_ldps_strap = 0, pin_iso_strap = 0, link_up = 0, rx_energy_det = 0;
  logic afe_en, pll_en, tx_en, dp_en, mgmt_en, mac_oe, wake_pulse_sel;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  phy_pwr_mode_ctrl dut (.*);

  // Inputs {pdn,aoff,ldps,pin_ldps,pin_iso,link}; outputs {afe,pll,tx,dp,mgmt,mac_oe,pulse}
  localparam int NV = 11;
  localparam logic [12:0] VEC [NV] = '{
    {6'b000000, 7'b1111110},   // R2 normal
    {6'b001000, 7'b1111111},   // R6 reg request, link down
    {6'b000100, 7'b1111111},   // R6 pin request
    {6'b001001, 7'b1111110},   // R6 link up
    {6'b010000, 7'b0001110},   // R3
    {6'b011000, 7'b0001110},   // R1 aoff over ldps
    {6'b100000, 7'b0000100},   // R4
    {6'b110100, 7'b0000100},   // R1 pdn over aoff/ldps
    {6'b000010, 7'b0000000},   // R5
    {6'b111110, 7'b0000000},   // R1 iso over all
    {6'b000001, 7'b1111110}    // R2 link up
  };

  function automatic logic [6:0] outs();
    return {afe_en, pll_en, tx_en, dp_en, mgmt_en, mac_oe, wake_pulse_sel};
  endfunction

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_in(input logic [5:0] v);
    {cfg_pdn, cfg_aoff, cfg_ldps, pin_ldps_strap, pin_iso_strap, link_up} = v;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    #1;
    check("R11 in reset", outs(), 7'b1111110);
    edges(2);
    rst_n = 1'b1;
    edges(1);
    check("R11 after reset", outs(), 7'b1111110);

    for (int i = 0; i < NV; i++) begin
      set_in(VEC[i][12:7]);
      edges(3);
      check($sformatf("R1 vector %0d", i), outs(), VEC[i][6:0]);
    end

    // R10: strap pin latency two edges
    set_in(6'b000000); edges(3);
    pin_iso_strap = 1; edges(1);
    check("R10 pin 1 edge", outs(), 7'b1111110);
    edges(1);
    check("R10 pin 2 edges", outs(), 7'b0000000);

    // R10: software bit latency and release
    set_in(6'b000000); edges(3);
    cfg_pdn = 1; edges(1);
    check("R10 pdn set", outs(), 7'b0000100);
    cfg_pdn = 0; edges(1);
    check("R10 pdn clear", outs(), 7'b1111110);

    // R7: energy wake
    cfg_ldps = 1; edges(2);
    check("R7 before strobe", outs(), 7'b1111111);
    rx_energy_det = 1; edges(1);
    rx_energy_det = 0;
    check("R7 one edge", outs(), 7'b1111111);
    edges(1);
    check("R7 two edges", outs(), 7'b1111110);
    edges(5);
    check("R7 held", outs(), 7'b1111110);

    // R8: link up then drop
    link_up = 1; edges(2);
    check("R8 link up", outs(), 7'b1111110);
    link_up = 0; edges(1);
    check("R8 relapse", outs(), 7'b1111111);

    // R9: energy while link up has no lasting effect
    link_up = 1; edges(2);
    rx_energy_det = 1; edges(1);
    rx_energy_det = 0; edges(2);
    link_up = 0; edges(1);
    check("R9 link-up strobe", outs(), 7'b1111111);

    // R9: energy outside link-down saving
    cfg_ldps = 0; edges(2);
    rx_energy_det = 1; edges(1);
    rx_energy_det = 0; edges(2);
    check("R9 normal strobe", outs(), 7'b1111110);
    cfg_ldps = 1; edges(2);
    check("R9 reenter", outs(), 7'b1111111);

    // R7/R8 same cycle: link drop and energy strobe together
    link_up = 1; edges(2);
    link_up = 0; rx_energy_det = 1; edges(1);
    rx_energy_det = 0;
    check("R8 same-cycle drop", outs(), 7'b1111111);
    edges(1);
    check("R7 same-cycle wake", outs(), 7'b1111110);

    // R1: power-down with pending link-down saving
    cfg_pdn = 1; edges(1);
    check("R1 pdn over ldps", outs(), 7'b0000100);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule